// File: doc/BRIEF.md
# Multiplexed Converter Serial Port Slave Model

This block is a synthesizable stand-in for the digital side of a multiplexed delta-sigma converter's serial port. It is used on a bench or in an emulation build to exercise a host-side serial controller without the real analog part. The model steps through three states: converting, sleeping with a result ready, and a 32-bit data transfer frame. In the transfer frame it shifts a result word out and takes a channel configuration in. Every input is treated as synchronous to the system clock `clk`, and the serial clock edges are found by comparing successive samples.

The conversion lasts a programmable number of system clocks. At its end the model takes one signed stimulus value from a valid/ready stream. The handshake rules are these. `stim_ready` is high only once the conversion count has expired, and it stays high until a transfer takes place. The value is captured in the cycle where `stim_valid` and `stim_ready` are both high. The source must hold `stim_data` steady while `stim_valid` waits. While `stim_valid` stays low the model remains in the converting state, so the host sees a conversion that has not finished. The captured value is encoded into the result word together with the channel address the conversion used. That word is then held until a frame has read it out in full.

Top module: `adc_serial_slave`

## Requirements
- R1: After reset the model is converting, the channel address reads 0 (differential pair, even sign, mux 0), and `stim_ready` is low.
- R2: `ser_dout_en` is high exactly when `sel_n` is low. When it is low the data line is released.
- R3: While converting with `sel_n` low, `ser_dout` is 1. Serial clock edges in this state change nothing.
- R4: `stim_ready` rises CONV_CYCLES-1 clocks after the clock that saw the 32nd falling serial edge. It then stays high, and the model stays converting with `ser_dout` 1, until `stim_valid` is seen high.
- R5: In sleep with `sel_n` low, `ser_dout` is 0 for the first cycle. Low `sel_n` moves the model into a transfer frame.
- R6: A frame presents word bit 31 first. The next bit appears after each falling serial edge, so bit 31-k is valid before rising edge k+1.
- R7: Word layout: [31]=0, [30]=0, [29:6]=24-bit code, [5:1]=address of the conversion that produced it ({single, odd, mux[2:0]}), [0]=XOR of bits 31..1.
- R8: The code is the stimulus plus 2^23, taken modulo 2^24, when the stimulus is at least -FS_LIM and below FS_LIM. A stimulus of FS_LIM or more gives 0xC00000. A stimulus below -FS_LIM gives 0x3FFFFF.
- R9: The first 8 rising serial edges of a frame carry the configuration, MSB first: two ignored bits, enable, single, odd, mux[2:0]. The address is committed at the 8th rising edge only if enable is 1, and `chan_addr` shows it from the next clock.
- R10: A rise of `sel_n` before the 8th rising edge, or in the same clock as it, discards the configuration and returns the model to sleep. The next frame restarts at bit 31 of the same word.
- R11: The 32nd falling serial edge starts a new conversion that uses the address then in `chan_addr`, and `ser_dout` reads 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_n | input | 1 | Active-low select from the host |
| ser_clk | input | 1 | Serial clock from the host, sampled by clk |
| ser_din | input | 1 | Configuration data from the host |
| ser_dout | output | 1 | Status and result data to the host |
| ser_dout_en | output | 1 | Drive enable for ser_dout |
| stim_data | input | 24 | Signed stimulus value |
| stim_valid | input | 1 | Stimulus offered |
| stim_ready | output | 1 | Conversion count expired, stimulus wanted |
| chan_addr | output | 5 | Address that the next conversion will use |

## Verification
Two events can land in the same system clock: a rise of `sel_n` and the 8th rising serial edge, which carries the last address bit. The bench provokes this by driving both lines in one step. In that collision the rise of select must win: the frame is abandoned, `chan_addr` keeps its old value, and the next frame re-reads the same word from bit 31. A rise that comes only after the 8th edge must let the commit stand. Comparing `chan_addr` after these two cases tells them apart.

// File: rtl/adcsl_pkg.sv
package adcsl_pkg;
  localparam int CODE_W = 24;
  localparam int CHAN_W = 5;
  localparam int CFG_W  = 8;
  localparam int WORD_W = 2 + CODE_W + CHAN_W + 1;

  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_XFER  = 2'd2
  } state_e;

  typedef struct packed {
    logic       single;
    logic       odd;
    logic [2:0] mux;
  } chan_t;

  localparam chan_t CHAN_DEFAULT = '{single: 1'b0, odd: 1'b0, mux: 3'd0};
endpackage

// File: rtl/adcsl_conv_timer.sv
module adcsl_conv_timer #(
  parameter int CONV_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic take,
  output logic busy,
  output logic at_end
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign at_end = busy && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (busy) begin
      if (take) begin
        busy <= 1'b0;
      end else if (cnt_q != LAST) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adcsl_result_fmt.sv
module adcsl_result_fmt
  import adcsl_pkg::*;
#(
  parameter int FS_LIM = 1 << 22
) (
  input  logic [CODE_W-1:0] stim,
  input  chan_t             chan,
  output logic [WORD_W-1:0] word
);
  localparam logic [CODE_W-1:0] CODE_OVER  = {2'b11, {(CODE_W-2){1'b0}}};
  localparam logic [CODE_W-1:0] CODE_UNDER = {2'b00, {(CODE_W-2){1'b1}}};

  logic signed [CODE_W-1:0] s_val;
  logic [CODE_W-1:0]        code;
  logic [WORD_W-1:1]        upper;

  assign s_val = $signed(stim);

  always_comb begin
    if (s_val >= FS_LIM) begin
      code = CODE_OVER;
    end else if (s_val < -FS_LIM) begin
      code = CODE_UNDER;
    end else begin
      code = {~stim[CODE_W-1], stim[CODE_W-2:0]};
    end
  end

  assign upper = {2'b00, code, chan};
  assign word  = {upper, ^upper};
endmodule

// File: rtl/adcsl_frame.sv
module adcsl_frame
  import adcsl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              sel_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic [WORD_W-1:0] word,
  output logic              bit_out,
  output logic              frame_done,
  output logic              cfg_commit,
  output chan_t             cfg_chan
);
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int KEEP_W = CFG_W - 3;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] CFG_END = IDX_W'(CFG_W - 1);

  logic              clk_q;
  logic [IDX_W-1:0]  idx_q;
  logic [KEEP_W-1:0] cfg_sr;
  logic [KEEP_W:0]   cfg_full;
  logic              live, rise, fall;

  assign live = active && !sel_n;
  assign rise = live && ser_clk && !clk_q;
  assign fall = live && !ser_clk && clk_q;

  assign cfg_full   = {cfg_sr, ser_din};
  assign cfg_chan   = chan_t'(cfg_full[CHAN_W-1:0]);
  assign cfg_commit = rise && (idx_q == CFG_END) && cfg_full[KEEP_W];
  assign frame_done = fall && (idx_q == TOP_IDX);
  assign bit_out    = word[TOP_IDX - idx_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_q <= 1'b0;
    end else begin
      clk_q <= ser_clk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      idx_q  <= '0;
      cfg_sr <= '0;
    end else begin
      if (fall) begin
        idx_q <= idx_q + 1'b1;
      end
      if (rise && (idx_q < CFG_END)) begin
        cfg_sr <= {cfg_sr[KEEP_W-2:0], ser_din};
      end
    end
  end
endmodule

// File: rtl/adc_serial_slave.sv
module adc_serial_slave
  import adcsl_pkg::*;
#(
  parameter int CONV_CYCLES = 64,
  parameter int FS_LIM      = 1 << 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  output logic              ser_dout,
  output logic              ser_dout_en,
  input  logic [CODE_W-1:0] stim_data,
  input  logic              stim_valid,
  output logic              stim_ready,
  output logic [CHAN_W-1:0] chan_addr
);
  state_e            state_q, state_d;
  chan_t             chan_act_q, conv_chan_q, cfg_chan;
  logic [WORD_W-1:0] result_q, word_fmt;
  logic              conv_busy, conv_at_end, take;
  logic              frame_done, cfg_commit, bit_out;

  assign take = stim_valid && conv_at_end;

  adcsl_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (frame_done),
    .take   (take),
    .busy   (conv_busy),
    .at_end (conv_at_end)
  );

  adcsl_result_fmt #(.FS_LIM(FS_LIM)) u_fmt (
    .stim (stim_data),
    .chan (conv_chan_q),
    .word (word_fmt)
  );

  adcsl_frame u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (state_q == ST_XFER),
    .sel_n      (sel_n),
    .ser_clk    (ser_clk),
    .ser_din    (ser_din),
    .word       (result_q),
    .bit_out    (bit_out),
    .frame_done (frame_done),
    .cfg_commit (cfg_commit),
    .cfg_chan   (cfg_chan)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_CONV:  if (take) state_d = ST_SLEEP;
      ST_SLEEP: if (!sel_n) state_d = ST_XFER;
      ST_XFER: begin
        if (sel_n) state_d = ST_SLEEP;
        else if (frame_done) state_d = ST_CONV;
      end
      default:  state_d = ST_CONV;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_CONV;
      chan_act_q  <= CHAN_DEFAULT;
      conv_chan_q <= CHAN_DEFAULT;
      result_q    <= '0;
    end else begin
      state_q <= state_d;
      if (take) result_q <= word_fmt;
      if (cfg_commit) chan_act_q <= cfg_chan;
      if (frame_done) conv_chan_q <= chan_act_q;
    end
  end

  always_comb begin
    ser_dout = 1'b0;
    if (!sel_n) begin
      unique case (state_q)
        ST_CONV:  ser_dout = 1'b1;
        ST_XFER:  ser_dout = bit_out;
        default:  ser_dout = 1'b0;
      endcase
    end
  end

  assign ser_dout_en = !sel_n;
  assign stim_ready  = conv_at_end;
  assign chan_addr   = chan_act_q;
endmodule

// File: rtl/adcsl_chk.sv
module adcsl_chk
  import adcsl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input state_e            state,
  input logic              busy,
  input logic              stim_ready,
  input logic              stim_valid,
  input logic              sel_n,
  input logic              ser_dout,
  input logic              frame_done,
  input logic [CHAN_W-1:0] chan_addr
);
  AST_STATE_MATCHES_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONV) == busy); // R4

  AST_READY_ONLY_CONVERTING: assert property (@(posedge clk) disable iff (!rst_n)
    stim_ready |-> (state == ST_CONV)); // R4

  AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (stim_ready && !stim_valid) |=> stim_ready); // R4

  AST_BUSY_DOUT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sel_n) |-> ser_dout); // R3

  AST_ADDR_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_XFER) |=> $stable(chan_addr)); // R9

  AST_DONE_STARTS_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (busy && state == ST_CONV)); // R11
endmodule

bind adc_serial_slave adcsl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .state      (state_q),
  .busy       (conv_busy),
  .stim_ready (stim_ready),
  .stim_valid (stim_valid),
  .sel_n      (sel_n),
  .ser_dout   (ser_dout),
  .frame_done (frame_done),
  .chan_addr  (chan_addr)
);

// File: tb/adc_serial_slave_tb.sv
module adc_serial_slave_tb;
  localparam int CONV = 64;
  localparam int FS   = 1 << 22;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1;
  logic        ser_clk = 1'b0;
  logic        ser_din = 1'b0;
  logic        ser_dout, ser_dout_en;
  logic [23:0] stim_data = '0;
  logic        stim_valid = 1'b0;
  logic        stim_ready;
  logic [4:0]  chan_addr;

  int n_chk = 0;
  int n_bad = 0;
  logic [4:0] m_act  = 5'd0;
  logic [4:0] m_conv = 5'd0;

  always #2.5 clk = ~clk;

  adc_serial_slave #(.CONV_CYCLES(CONV), .FS_LIM(FS)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_dout(ser_dout), .ser_dout_en(ser_dout_en), .stim_data(stim_data),
    .stim_valid(stim_valid), .stim_ready(stim_ready), .chan_addr(chan_addr)
  );

  function automatic logic [31:0] exp_word(input int s, input logic [4:0] ch);
    logic [23:0] code;
    logic [31:0] w;
    if (s >= FS) code = 24'hC00000;
    else if (s < -FS) code = 24'h3FFFFF;
    else code = 24'(s + (1 << 23));
    w = {2'b00, code, ch, 1'b0};
    w[0] = ^w[31:1];
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic feed(input int s);
    stim_data  = 24'(s);
    stim_valid = 1'b1;
    while (!stim_ready) tick(1);
    tick(1);
    stim_valid = 1'b0;
  endtask

  // nrise: rising edges given before select rises (32 = full frame)
  task automatic frame(input logic [7:0] cfg, input int nrise, input bit same,
                       output logic [31:0] got);
    got = '0;
    sel_n = 1'b0;
    tick(2);
    for (int i = 0; i < 32; i++) begin
      got[31-i] = ser_dout;
      ser_din = (i < 8) ? cfg[7-i] : 1'($urandom);
      ser_clk = 1'b1;
      if (same && nrise < 32 && i == nrise - 1) begin
        sel_n = 1'b1;
        tick(2);
        ser_clk = 1'b0;
        tick(2);
        return;
      end
      tick(2);
      ser_clk = 1'b0;
      tick(2);
      if (nrise < 32 && i == nrise - 1) begin
        sel_n = 1'b1;
        tick(2);
        return;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] got, expw;
    logic [7:0]  cfg;
    int s, cnt, nr, seed;
    bit same;
    seed = $urandom(32'd2024);

    tick(4);
    rst_n = 1'b1;
    tick(1);
    check("R1 chan_addr", 32'(chan_addr), 32'd0);
    check("R1 stim_ready", 32'(stim_ready), 32'd0);
    check("R2 released", 32'(ser_dout_en), 32'd0);
    sel_n = 1'b0;
    tick(1);
    check("R1 converting dout", 32'(ser_dout), 32'd1);
    check("R2 driven", 32'(ser_dout_en), 32'd1);
    for (int k = 0; k < 8; k++) begin
      ser_clk = ~ser_clk;
      tick(2);
      check("R3 dout during conv", 32'(ser_dout), 32'd1);
    end
    ser_clk = 1'b0;
    sel_n = 1'b1;

    for (int it = 0; it < 40; it++) begin
      case (it)
        0: s = 0;
        1: s = -1;
        2: s = FS - 1;
        3: s = FS;
        4: s = -FS;
        5: s = -FS - 1;
        default: begin
          case ($urandom_range(0, 3))
            0: s = FS + int'($urandom_range(0, (1 << 23) - 1 - FS));
            1: s = -FS - 1 - int'($urandom_range(0, (1 << 23) - 1 - FS));
            default: s = int'($urandom_range(0, 2 * FS - 1)) - FS;
          endcase
        end
      endcase
      feed(s);
      expw = exp_word(s, m_conv);
      sel_n = 1'b0;
      #1;
      check("R5 sleep dout", 32'(ser_dout), 32'd0);

      if (it % 3 == 1) begin
        cfg = 8'($urandom);
        cfg[5] = 1'b1;
        nr = (it % 2 == 0) ? 8 : int'($urandom_range(1, 8));
        same = (nr == 8) ? (it % 4 == 1) : 1'($urandom);
        frame(cfg, nr, same, got);
        if (nr == 8 && !same) m_act = cfg[4:0];
        check("R10 abort addr", 32'(chan_addr), 32'(m_act));
        check("R10 prefix", 32'(got >> (32 - nr)), 32'(expw >> (32 - nr)));
      end

      cfg = 8'($urandom);
      frame(cfg, 32, 1'b0, got);
      check("R11 dout after frame", 32'(ser_dout), 32'd1);
      sel_n = 1'b1;
      check("R6 R7 R8 word", got, expw);
      if (cfg[5]) m_act = cfg[4:0];
      check("R9 chan_addr", 32'(chan_addr), 32'(m_act));
      m_conv = m_act;

      if (it == 2) begin
        // frame returned two clocks after the 32nd fall was sampled
        cnt = 0;
        while (!stim_ready && cnt < 4 * CONV) begin
          tick(1);
          cnt++;
        end
        check("R4 conv length", 32'(cnt), 32'(CONV - 2));
        sel_n = 1'b0;
        tick(10);
        check("R4 ready held", 32'(stim_ready), 32'd1);
        check("R4 still converting", 32'(ser_dout), 32'd1);
        sel_n = 1'b1;
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule